// File: doc/BRIEF.md
# Serial-Loaded Bank Register File

This block is the write side of a cartridge memory-banking controller's configuration port. The CPU writes bytes anywhere in the upper half of its 64 KB address space. Each write carries one data bit, taken from bit 0 of the byte. The block gathers five such bits, least significant first. On the fifth accepted write it commits the 5-bit value to one of four configuration registers. The register is chosen by the address range of that fifth write.

Setting bit 7 of any write in the window abandons a partial load. The next write then starts again at bit position 0. Writes below the window and cycles without a strobe leave all state alone. The four register values are driven continuously on one flat output bus for the bank-switching logic that uses them.

The write port is a plain strobe with no back-pressure. The block accepts every strobed write in the cycle it is presented. There is no ready signal, and a write is never held off or queued.

Top module: `sbr_bank_regfile`

## Requirements
- R1: After reset, all four registers read zero, and the next five window writes form a fresh value starting at bit 0.
- R2: A write at address 0x8000–0xFFFF selects register k = address bits [14:13]. Register k is driven on `cfg_bus[5k+4:5k]`.
- R3: Only data bit 0 is taken as the serial bit. Bits 1–6 of the byte have no effect on any result.
- R4: The five data bits fill the value LSB-first. The first write gives bit 0 and the fifth gives bit 4. The target register is updated at the clock edge of the fifth write, and never before it.
- R5: The register that receives the value is the one addressed by the fifth write. The addresses of the first four writes do not matter.
- R6: After a commit the bit position returns to 0. The following five writes build a new, independent value.
- R7: A window write with bit 7 set discards the partial value and restarts at bit 0. It changes no committed register and contributes no data bit.
- R8: Writes with address below 0x8000 are ignored. They do not advance the bit position or touch any register.
- R9: A write takes effect only on a clock edge with `cpu_wr` high, and each such edge advances the position at most once. Address and data presented with `cpu_wr` low have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_wr | input | 1 | Write strobe, sampled on each rising edge |
| cpu_addr | input | 16 | Write address |
| cpu_data | input | 8 | Write data; bit 0 is serial data, bit 7 is restart |
| cfg_bus | output | 20 | Four 5-bit registers, register k in bits [5k+4:5k] |

## Verification
Every result of this block is due one clock edge after the strobe that causes it. A committed value appears on `cfg_bus` right after the rising edge of the fifth write. Restarts and ignored writes show their effect, or their lack of one, over the writes that follow.

The bench drives each write on a falling edge and holds the strobe for exactly one rising edge. It then compares the bus on the next falling edge. After the first four writes of each load it checks that the target register has not yet changed, so an early or late commit is caught on the exact cycle.

// File: rtl/sbr_pkg.sv
package sbr_pkg;
  localparam int ADDR_W  = 16;
  localparam int DATA_W  = 8;
  localparam int REG_W   = 5;
  localparam int REG_N   = 4;
  localparam int SEL_W   = $clog2(REG_N);
  localparam int PTR_W   = $clog2(REG_W);
  localparam int CLR_BIT = 7;

  typedef logic [REG_W-1:0] cfg_t;
  typedef logic [SEL_W-1:0] sel_t;
endpackage

// File: rtl/sbr_addr_decode.sv
module sbr_addr_decode
  import sbr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int SW = SEL_W
) (
  input  logic [AW-1:0] addr,
  output logic          in_window,
  output logic [SW-1:0] sel
);
  // Upper half of the address space is the window; the next bits pick the register.
  always_comb begin
    in_window = addr[AW-1];
    sel       = addr[AW-2 -: SW];
  end
endmodule

// File: rtl/sbr_shift_collect.sv
module sbr_shift_collect
  import sbr_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int RW  = REG_W,
  parameter int CLR = CLR_BIT
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic          hit,
  input  logic [DW-1:0] data,
  output logic          commit,
  output logic [RW-1:0] value
);
  localparam int PW = (RW > 1) ? $clog2(RW) : 1;
  localparam logic [PW-1:0] LAST = PW'(RW - 1);

  logic [RW-1:0] acc_q, acc_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          take, restart;

  always_comb begin
    take    = wr && hit;
    restart = take && data[CLR];
    acc_d   = acc_q;
    ptr_d   = ptr_q;
    commit  = 1'b0;
    value   = acc_q;
    if (restart) begin
      acc_d = '0;
      ptr_d = '0;
    end else if (take) begin
      value        = acc_q;
      value[ptr_q] = data[0];
      if (ptr_q == LAST) begin
        commit = 1'b1;
        acc_d  = '0;
        ptr_d  = '0;
      end else begin
        acc_d = value;
        ptr_d = ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
      ptr_q <= '0;
    end else begin
      acc_q <= acc_d;
      ptr_q <= ptr_d;
    end
  end

  AST_PTR_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    ptr_q <= LAST);                                                       // R6
  AST_RESTART_ZEROES: assert property (@(posedge clk) disable iff (rst)
    (wr && hit && data[CLR]) |=> (ptr_q == '0 && acc_q == '0));           // R7
  AST_OUTSIDE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr && !hit) |=> ($stable(ptr_q) && $stable(acc_q)));                 // R8
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !wr |=> ($stable(ptr_q) && $stable(acc_q)));                          // R9
  AST_COMMIT_REWINDS: assert property (@(posedge clk) disable iff (rst)
    commit |=> (ptr_q == '0));                                            // R6
endmodule

// File: rtl/sbr_reg_bank.sv
module sbr_reg_bank
  import sbr_pkg::*;
#(
  parameter int RW = REG_W,
  parameter int RN = REG_N,
  parameter int SW = SEL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             commit,
  input  logic [SW-1:0]    sel,
  input  logic [RW-1:0]    value,
  output logic [RN*RW-1:0] regs
);
  logic [RN-1:0] load;

  for (genvar k = 0; k < RN; k++) begin : g_reg
    logic [RW-1:0] r_q;
    assign load[k] = commit && (sel == SW'(k));
    always_ff @(posedge clk) begin
      if (rst)          r_q <= '0;
      else if (load[k]) r_q <= value;
    end
    assign regs[k*RW +: RW] = r_q;
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
    $onehot0(load));                                                      // R2
  AST_NO_COMMIT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !commit |=> $stable(regs));                                           // R4
endmodule

// File: rtl/sbr_bank_regfile.sv
module sbr_bank_regfile
  import sbr_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W,
  parameter int RW = REG_W,
  parameter int RN = REG_N
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cpu_wr,
  input  logic [AW-1:0]    cpu_addr,
  input  logic [DW-1:0]    cpu_data,
  output logic [RN*RW-1:0] cfg_bus
);
  localparam int SW = $clog2(RN);

  logic          hit, commit;
  logic [SW-1:0] sel;
  logic [RW-1:0] value;

  sbr_addr_decode #(.AW(AW), .SW(SW)) u_dec (
    .addr(cpu_addr), .in_window(hit), .sel(sel)
  );

  sbr_shift_collect #(.DW(DW), .RW(RW), .CLR(CLR_BIT)) u_col (
    .clk(clk), .rst(rst), .wr(cpu_wr), .hit(hit), .data(cpu_data),
    .commit(commit), .value(value)
  );

  sbr_reg_bank #(.RW(RW), .RN(RN), .SW(SW)) u_bank (
    .clk(clk), .rst(rst), .commit(commit), .sel(sel), .value(value),
    .regs(cfg_bus)
  );

  AST_COMMIT_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    commit |-> (cpu_wr && cpu_addr[AW-1]));                               // R8
endmodule

// File: tb/test_sbr_bank_regfile.sv
module test_sbr_bank_regfile;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_wr = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_data = '0;
  logic [19:0] cfg_bus;

  int total = 0;
  int bad = 0;
  logic [4:0] exp_r [4];

  always #5 clk = ~clk;

  sbr_bank_regfile i_sbr_bank_regfile (
    .clk(clk), .rst(rst), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
    .cpu_data(cpu_data), .cfg_bus(cfg_bus)
  );

  task automatic check_all(input string req);
    for (int k = 0; k < 4; k++) begin
      total++;
      if (cfg_bus[k*5 +: 5] !== exp_r[k]) begin
        bad++;
        $display("FAIL %s reg%0d actual=%h expected=%h", req, k, cfg_bus[k*5 +: 5], exp_r[k]);
      end
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    cpu_wr = 1'b1; cpu_addr = a; cpu_data = d;
    @(negedge clk);
    cpu_wr = 1'b0;
  endtask

  // Four writes (bits 0..3), checked unchanged, then a fifth to addr5.
  task automatic load5(input logic [15:0] a, input logic [15:0] a5,
                       input logic [4:0] v, input logic [7:0] hi, input string req);
    for (int b = 0; b < 4; b++) wr(a, hi | {7'd0, v[b]});
    check_all({req, "/R4-hold"});
    wr(a5, hi | {7'd0, v[4]});
    exp_r[a5[14:13]] = v;
    check_all(req);
  endtask

  task automatic t_reset;
    for (int k = 0; k < 4; k++) exp_r[k] = '0;
    check_all("R1");
  endtask

  task automatic t_regions;
    load5(16'h8000, 16'h9FFF, 5'h15, 8'h00, "R2");
    load5(16'hA000, 16'hBFFF, 5'h0A, 8'h00, "R2");
    load5(16'hC123, 16'hDFFF, 5'h1F, 8'h00, "R2");
    load5(16'hE000, 16'hFFFF, 5'h13, 8'h00, "R2");
  endtask

  task automatic t_lsb_first;
    load5(16'h8000, 16'h8000, 5'h01, 8'h00, "R4");
    load5(16'h8000, 16'h8000, 5'h10, 8'h00, "R4");
  endtask

  task automatic t_upper_bits_ignored;
    load5(16'hA000, 16'hA000, 5'h0C, 8'h7E, "R3");
  endtask

  task automatic t_fifth_addr_wins;
    load5(16'hE000, 16'hA555, 5'h1B, 8'h00, "R5");
  endtask

  task automatic t_back_to_back;
    load5(16'hC000, 16'hC000, 5'h06, 8'h00, "R6");
    load5(16'hC000, 16'hC000, 5'h19, 8'h00, "R6");
  endtask

  task automatic t_restart;
    wr(16'h8000, 8'h01); wr(16'h8000, 8'h01); wr(16'h8000, 8'h01);
    wr(16'hE000, 8'h81);
    check_all("R7-no-change");
    load5(16'h8000, 16'h8000, 5'h12, 8'h00, "R7");
    wr(16'h8000, 8'h01); wr(16'h8000, 8'h01); wr(16'h8000, 8'h01); wr(16'h8000, 8'h01);
    wr(16'h8000, 8'h80);
    check_all("R7-fifth-restart");
    load5(16'h8000, 16'h8000, 5'h04, 8'h00, "R7");
  endtask

  task automatic t_low_addr;
    wr(16'hC000, 8'h01); wr(16'h7FFF, 8'h00); wr(16'h0000, 8'h81);
    wr(16'hC000, 8'h00); wr(16'h4000, 8'h01);
    wr(16'hC000, 8'h01); wr(16'hC000, 8'h01);
    check_all("R8-hold");
    wr(16'hC000, 8'h00);
    exp_r[2] = 5'h0D;
    check_all("R8");
  endtask

  task automatic t_strobe_low;
    wr(16'h8000, 8'h01); wr(16'h8000, 8'h01);
    @(negedge clk);
    cpu_addr = 16'h8000; cpu_data = 8'h00;
    repeat (3) @(negedge clk);
    cpu_data = 8'h80;
    @(negedge clk);
    wr(16'h8000, 8'h01); wr(16'h8000, 8'h01);
    check_all("R9-hold");
    wr(16'h8000, 8'h00);
    exp_r[0] = 5'h0F;
    check_all("R9");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regions();
    t_lsb_first();
    t_upper_bits_ignored();
    t_fifth_addr_wins();
    t_back_to_back();
    t_restart();
    t_low_addr();
    t_strobe_low();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    t_reset();
    load5(16'hE000, 16'hE000, 5'h11, 8'h00, "R1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule